// File: doc/BRIEF.md
# Signaling Buffer Freeze Controller

This block sits between the robbed-bit signaling extractor of a T1/J1 receive framer and the receive signaling buffer. Each cycle it decides whether newly extracted signaling bits may be written into the buffer, or whether the buffer must keep what it already holds. The decision combines a software force bit with automatic causes: loss of signal, loss of frame alignment, and a receive slip. A slip only counts when external register access to the signaling buffer is switched on.

Freezing takes effect in the same cycle that a cause appears. Release is delayed. After every cause has gone, the block waits for the next superframe boundary, then for one more complete, clean superframe. A superframe that was already in progress when the causes cleared is not counted. If any cause returns during this wait, the wait starts over. The freeze status drives a dedicated pin output and a copy for a status register. The per-lane write enables are the incoming write strobes, blocked while the status is set.

Top module: `sig_freeze_ctrl`

## Requirements
- R1: After reset the freeze status is 0 on both status outputs, and every write strobe passes through to its write enable.
- R2: While the force-freeze input is 1, the freeze status is 1 in that same cycle, whatever the other inputs are.
- R3: While the loss-of-signal input is 1, the freeze status is 1 in that same cycle.
- R4: While the loss-of-frame-alignment input is 1, the freeze status is 1 in that same cycle.
- R5: While the slip input and the access-enable input are both 1, the freeze status is 1 in that same cycle.
- R6: While access-enable is 0, the slip input has no effect: the freeze status stays 0 and write strobes pass, including across superframe boundaries.
- R7: Once all causes are 0, the freeze status stays 1 through the first superframe-boundary strobe. It stays 1 through the whole following superframe, including the cycle of the next boundary strobe. It becomes 0 in the cycle after that second boundary. A boundary strobe that arrives while any cause is 1 does not count.
- R8: A cause that reappears at any point in the recovery wait restarts it, so two further clean boundary strobes are needed again.
- R9: The pin output and the status-register output always carry the same freeze value.
- R10: Write enable for lane k equals write strobe k while the freeze status is 0, and is 0 while the freeze status is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| force_freeze_i | input | 1 | Software force-freeze control bit |
| los_i | input | 1 | Loss-of-signal alarm level |
| lfa_i | input | 1 | Loss-of-frame-alignment alarm level |
| slip_i | input | 1 | Receive slip indication |
| ext_access_en_i | input | 1 | External register access to signaling buffer enabled |
| sf_boundary_i | input | 1 | One-cycle strobe at the last cycle of each superframe |
| chan_wr_i | input | LANES | Per-lane signaling write strobes from the extractor |
| buf_wr_en_o | output | LANES | Gated write enables to the signaling buffer |
| freeze_pin_o | output | 1 | Freeze status for the multifunction pin |
| freeze_stat_o | output | 1 | Freeze status for the status register bit |

## Verification
The bench sweeps all 32 combinations of force, loss of signal, loss of alignment, slip and access-enable from a clean start, with both write lanes strobing. This shows that each cause freezes alone and in combination, and that a slip counts only with access enabled. Recovery sequences then clear the causes in mid-superframe, send boundaries while a cause is still held, and let causes overlap and release one at a time. These separate a correct two-boundary release from releasing on the first boundary or at once. A cause injected during each phase of the wait checks that the wait restarts instead of resuming.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [1:0] {
        SFC_RUN        = 2'd0,
        SFC_WAIT_START = 2'd1,
        SFC_WAIT_END   = 2'd2
    } sfc_state_e;

    typedef struct packed {
        sfc_state_e state;
    } sfc_regs_t;

    localparam sfc_regs_t SFC_RESET = '{state: SFC_RUN};

endpackage

// File: rtl/sfc_cause_merge.sv
module sfc_cause_merge (
    input  logic force_freeze_i,
    input  logic los_i,
    input  logic lfa_i,
    input  logic slip_i,
    input  logic ext_access_en_i,
    output logic cause_o
);
    logic slip_eff;

    always_comb begin
        slip_eff = slip_i & ext_access_en_i;
        cause_o  = force_freeze_i | los_i | lfa_i | slip_eff;
    end
endmodule

// File: rtl/sfc_recovery_fsm.sv
module sfc_recovery_fsm
    import sfc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cause_i,
    input  logic sf_boundary_i,
    output logic frozen_o
);
    sfc_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cause_i) begin
            regs_d.state = SFC_WAIT_START;
        end else begin
            unique case (regs_q.state)
                SFC_RUN:        regs_d.state = SFC_RUN;
                SFC_WAIT_START: if (sf_boundary_i) regs_d.state = SFC_WAIT_END;
                SFC_WAIT_END:   if (sf_boundary_i) regs_d.state = SFC_RUN;
                default:        regs_d.state = SFC_WAIT_START;
            endcase
        end
        frozen_o = cause_i | (regs_q.state != SFC_RUN);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) regs_q <= SFC_RESET;
        else         regs_q <= regs_d;
    end

    // R8: any cause sends the next state back to the start of the wait
    p_cause_restarts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cause_i |=> regs_q.state == SFC_WAIT_START);

    // R7: leaving the wait needs a clean boundary in the end phase
    p_release_on_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.state != SFC_RUN && !(regs_q.state == SFC_WAIT_END && sf_boundary_i && !cause_i))
        |=> regs_q.state != SFC_RUN);

    // R7: the start phase only advances on a clean boundary
    p_start_needs_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.state == SFC_WAIT_START && !sf_boundary_i) |=> regs_q.state == SFC_WAIT_START);
endmodule

// File: rtl/sfc_wr_gate.sv
module sfc_wr_gate #(
    parameter int LANES = 2
) (
    input  logic             frozen_i,
    input  logic [LANES-1:0] chan_wr_i,
    output logic [LANES-1:0] buf_wr_en_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign buf_wr_en_o[g] = chan_wr_i[g] & ~frozen_i;
    end
endmodule

// File: rtl/sig_freeze_ctrl.sv
module sig_freeze_ctrl #(
    parameter int LANES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             force_freeze_i,
    input  logic             los_i,
    input  logic             lfa_i,
    input  logic             slip_i,
    input  logic             ext_access_en_i,
    input  logic             sf_boundary_i,
    input  logic [LANES-1:0] chan_wr_i,
    output logic [LANES-1:0] buf_wr_en_o,
    output logic             freeze_pin_o,
    output logic             freeze_stat_o
);
    logic cause;
    logic frozen;

    sfc_cause_merge u_merge (
        .force_freeze_i (force_freeze_i),
        .los_i          (los_i),
        .lfa_i          (lfa_i),
        .slip_i         (slip_i),
        .ext_access_en_i(ext_access_en_i),
        .cause_o        (cause)
    );

    sfc_recovery_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cause_i      (cause),
        .sf_boundary_i(sf_boundary_i),
        .frozen_o     (frozen)
    );

    sfc_wr_gate #(.LANES(LANES)) u_gate (
        .frozen_i   (frozen),
        .chan_wr_i  (chan_wr_i),
        .buf_wr_en_o(buf_wr_en_o)
    );

    assign freeze_pin_o  = frozen;
    assign freeze_stat_o = frozen;

    p_force_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_freeze_i |-> (freeze_pin_o && buf_wr_en_o == '0));
    p_los_freezes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        los_i |-> freeze_pin_o);
    p_lfa_freezes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfa_i |-> freeze_pin_o);
    p_slip_freezes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slip_i && ext_access_en_i) |-> freeze_pin_o);
    p_frozen_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_stat_o |-> buf_wr_en_o == '0);
    p_unfrozen_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !freeze_pin_o |-> buf_wr_en_o == chan_wr_i);
endmodule

// File: tb/sig_freeze_ctrl_tb_top.sv
module sig_freeze_ctrl_tb_top;
    localparam int LANES = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frc = 0, los = 0, lfa = 0, slp = 0, acc = 0, sfb = 0;
    logic [LANES-1:0] wr = '0;
    logic [LANES-1:0] wen;
    logic frz_pin, frz_stat;
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    sig_freeze_ctrl #(.LANES(LANES)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .force_freeze_i(frc), .los_i(los),
        .lfa_i(lfa), .slip_i(slp), .ext_access_en_i(acc), .sf_boundary_i(sfb),
        .chan_wr_i(wr), .buf_wr_en_o(wen), .freeze_pin_o(frz_pin),
        .freeze_stat_o(frz_stat)
    );

    // c = {force, los, lfa, slip, access}; inputs change at falling edge
    task automatic drive(input logic [4:0] c, input logic b, input logic [LANES-1:0] w);
        @(negedge clk);
        {frc, los, lfa, slp, acc} = c;
        sfb = b;
        wr  = w;
        #1;
    endtask

    task automatic chk(input string req, input logic exp_frz);
        logic [LANES-1:0] exp_wen;
        exp_wen = exp_frz ? '0 : wr;
        n_run++;
        if (frz_pin !== exp_frz || frz_stat !== exp_frz || wen !== exp_wen) begin
            n_fail++;
            $display("FAIL %s: pin=%b stat=%b wen=%b expected frz=%b wen=%b",
                     req, frz_pin, frz_stat, wen, exp_frz, exp_wen);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        {frc, los, lfa, slp, acc, sfb} = '0;
        wr = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        drive(5'b00000, 0, 2'b11); chk("R1 after reset", 0);
        drive(5'b00000, 0, 2'b01); chk("R1 lane pass", 0);

        // Sweep every cause combination from a clean start (R2..R6, R9, R10)
        for (int v = 0; v < 32; v++) begin
            logic exp;
            logic [4:0] c;
            c = v[4:0];
            exp = c[4] | c[3] | c[2] | (c[1] & c[0]);
            do_reset();
            drive(c, 0, 2'b11);
            if (c[4])               chk("R2 force sweep", exp);
            else if (c[3])          chk("R3 los sweep", exp);
            else if (c[2])          chk("R4 lfa sweep", exp);
            else if (c[1] & c[0])   chk("R5 slip with access sweep", exp);
            else                    chk("R6 R9 R10 no cause sweep", exp);
            drive(c, 1, 2'b10);
            chk("R10 second cycle sweep", exp);
        end

        // R6: slip with access off across boundaries
        do_reset();
        for (int i = 0; i < 6; i++) begin
            drive(5'b00010, (i % 2) == 1, 2'b11);
            chk("R6 slip ignored", 0);
        end

        // R7: mid-superframe release, two boundaries needed
        do_reset();
        drive(5'b01000, 0, 2'b11); chk("R3 los on", 1);
        drive(5'b01000, 1, 2'b11); chk("R7 boundary under cause", 1);
        drive(5'b00000, 0, 2'b11); chk("R7 cleared mid superframe", 1);
        drive(5'b00000, 0, 2'b11); chk("R7 partial superframe", 1);
        drive(5'b00000, 1, 2'b11); chk("R7 first boundary", 1);
        drive(5'b00000, 0, 2'b11); chk("R7 full superframe wait", 1);
        drive(5'b00000, 0, 2'b01); chk("R7 full superframe wait", 1);
        drive(5'b00000, 1, 2'b11); chk("R7 second boundary still frozen", 1);
        drive(5'b00000, 0, 2'b11); chk("R7 released", 0);
        drive(5'b00000, 1, 2'b10); chk("R7 stays released", 0);

        // R8: cause during end phase restarts the wait
        do_reset();
        drive(5'b00100, 0, 2'b11); chk("R4 lfa on", 1);
        drive(5'b00000, 1, 2'b11); chk("R7 first boundary", 1);
        drive(5'b00011, 0, 2'b11); chk("R5 slip in wait", 1);
        drive(5'b00000, 1, 2'b11); chk("R8 restart first boundary", 1);
        drive(5'b00000, 0, 2'b11); chk("R8 restarted wait", 1);
        drive(5'b00000, 1, 2'b11); chk("R8 second boundary", 1);
        drive(5'b00000, 0, 2'b11); chk("R8 released", 0);

        // R8: cause during start phase
        do_reset();
        drive(5'b10000, 0, 2'b11); chk("R2 force on", 1);
        drive(5'b00000, 0, 2'b11); chk("R7 start phase", 1);
        drive(5'b01000, 1, 2'b11); chk("R8 cause on boundary", 1);
        drive(5'b00000, 1, 2'b11); chk("R8 first clean boundary", 1);
        drive(5'b00000, 1, 2'b11); chk("R8 second clean boundary", 1);
        drive(5'b00000, 0, 2'b11); chk("R8 released after restart", 0);

        // Overlap: force and los, release one at a time
        do_reset();
        drive(5'b11000, 0, 2'b11); chk("R2 overlap", 1);
        drive(5'b01000, 1, 2'b11); chk("R3 los remains", 1);
        drive(5'b01000, 1, 2'b11); chk("R3 los remains boundary", 1);
        drive(5'b00000, 0, 2'b11); chk("R7 all clear", 1);
        drive(5'b00000, 1, 2'b11); chk("R7 boundary one", 1);
        drive(5'b00000, 1, 2'b11); chk("R7 boundary two", 1);
        drive(5'b00000, 0, 2'b11); chk("R7 overlap released", 0);

        // R1: reset mid-freeze clears state
        drive(5'b01000, 0, 2'b11); chk("R3 los before reset", 1);
        do_reset();
        drive(5'b00000, 0, 2'b11); chk("R1 reset clears freeze", 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule